// File: doc/BRIEF.md
# PLL Frequency Change Sequencer

This block moves one of four per-cluster PLLs to a new operating frequency without software stepping through the sequence. A single-cycle start request carries a cluster index and a two-bit frequency selection. The block first puts the selected PLL into bypass and holds both of its active-low resets. It then writes the divider, fractional and loop-gain words and releases the core reset. Next it pulses the VCO update and polls that cluster's lock input within a bounded window. Finally it releases the post-divider reset, removes bypass and reports the result with a one-cycle done pulse.

Frequency selection codes are 1 (full), 2 (half) and 3 (quarter). Code 0 is rejected. A combinational readback port turns the integer divider that a cluster currently holds back into a frequency code.

The controller moves through named states. IDLE goes to BYPASS on an accepted start. BYPASS goes to RESET, RESET to PROGRAM, PROGRAM to RELEASE, RELEASE to UPDATE, and UPDATE to LOCKWAIT. LOCKWAIT goes to POSTREL on lock-seen or on poll-expired. POSTREL then goes to UNBYPASS, UNBYPASS to FINISH, and FINISH back to IDLE. A start with code 0 keeps the controller in IDLE and raises done together with bad_sel.

Top module: `pll_freq_seq`

## Requirements
- R1: After reset, every cluster has core_rst_n=1, post_rst_n=1, bypass=0, an all-zero divider, fractional and gain word, and no update pulse. busy, done, ok, timeout and bad_sel are all 0, and readback returns code 0.
- R2: Call the clock edge that samples start edge 0. At edges 1 to 5 the selected cluster goes through these steps, one per edge: bypass set; both resets driven low; words written; core reset released with the post reset still low; VCO update pulse. Lock polling starts at edge 6. After lock-seen or poll-expired the next three edges release the post reset, clear bypass and raise done. busy is high from edge 0 until done.
- R3: The divider word places the integer divider in bits 9:0, 0 in bits 11:10, and the post divider value 1 in bits 15:12. Code 1 gives 0x78, code 2 gives 0x3C and code 3 gives 0x1E. The 20-bit fractional word (low half in bits 9:0, high half in bits 19:10) is written as 0.
- R4: The gain word is written as 0xC823: proportional gain 3 in bits 3:0, integral gain 2 in bits 6:4, fast-lock gain 0 in bits 9:7, reference value 50 in bits 19:10.
- R5: A start with selection code 0 gives done=1 and bad_sel=1 one edge later, keeps busy at 0 and changes no cluster output.
- R6: Lock is sampled every POLL_GAP cycles, first at edge 5+POLL_GAP. The wait ends at the first sample that sees lock, so done appears 8+POLL_GAP*j edges after start, where j is the index of that sample.
- R7: If none of the POLL_LIMIT samples sees lock, done still appears, at edge 8+POLL_GAP*POLL_LIMIT, with timeout=1 and ok=0. The post reset is still released and bypass is still cleared. On a locked run ok=1 and timeout=0.
- R8: Cluster indices 0 to 3 each act only on their own register set. Any index of 4 or above acts on cluster 0.
- R9: Readback maps divider 0x78 to code 1, 0x3C to code 2, 0x1E to code 3 and any other value to 0. A readback index of 4 or above reads cluster 0.
- R10: The VCO update pulse and done each last exactly one cycle.
- R11: A start raised while busy is ignored: no other cluster changes and no second done follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request |
| cluster_i | input | IDX_W | Target cluster index |
| freq_sel_i | input | 2 | Frequency code |
| lock_i | input | N_CLUSTERS | Per-cluster lock status |
| rb_cluster_i | input | IDX_W | Readback cluster index |
| core_rst_n_o | output | N_CLUSTERS | Active-low PLL core reset per cluster |
| post_rst_n_o | output | N_CLUSTERS | Active-low post-divider reset per cluster |
| bypass_o | output | N_CLUSTERS | Bypass enable per cluster |
| div_word_o | output | 16*N_CLUSTERS | Divider word per cluster |
| frac_word_o | output | 20*N_CLUSTERS | Fractional divider word per cluster |
| gain_word_o | output | 20*N_CLUSTERS | Loop gain word per cluster |
| vco_upd_o | output | N_CLUSTERS | VCO update pulse per cluster |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Last sequence locked |
| timeout_o | output | 1 | Last sequence ran out of lock polls |
| bad_sel_o | output | 1 | Last request had an unsupported code |
| rb_code_o | output | 2 | Frequency code decoded from the readback cluster |

## Verification
The bench varies the lock delay on each side of every poll boundary and counts edges from start to done. A design that samples lock at the wrong point, or keeps polling after lock, shows up as a count that is off by POLL_GAP. A lock delay past the poll window checks that a timed-out run still releases the post reset and clears bypass, rather than hanging or leaving the PLL bypassed. An out-of-range index, code 0 and a start raised mid-sequence check three things: that a decode without fallback writes to no cluster, that a missing validity check corrupts a divider, and that a sequencer which re-arms while busy reprograms a second cluster.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    localparam int NDIV_W = 10;
    localparam int PDIV_W = 4;
    localparam int DIVW_W = 16;
    localparam int HALF_W = 10;
    localparam int FRAC_W = 2 * HALF_W;
    localparam int GAIN_W = 20;

    localparam logic [PDIV_W-1:0] PDIV_VAL = 4'd1;

    localparam logic [1:0] FSEL_FULL = 2'd1;
    localparam logic [1:0] FSEL_HALF = 2'd2;
    localparam logic [1:0] FSEL_QRTR = 2'd3;

    localparam logic [NDIV_W-1:0] NDIV_FULL = 10'h078;
    localparam logic [NDIV_W-1:0] NDIV_HALF = 10'h03C;
    localparam logic [NDIV_W-1:0] NDIV_QRTR = 10'h01E;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BYPASS,
        ST_RESET,
        ST_PROGRAM,
        ST_RELEASE,
        ST_UPDATE,
        ST_LOCKWAIT,
        ST_POSTREL,
        ST_UNBYPASS,
        ST_FINISH
    } pfs_state_t;

    typedef struct packed {
        logic byp_on;
        logic byp_off;
        logic rst_all;
        logic prog;
        logic core_rel;
        logic post_rel;
        logic vco_pulse;
    } pfs_act_t;

    function automatic logic sel_valid(input logic [1:0] sel);
        return sel != 2'd0;
    endfunction

    function automatic logic [NDIV_W-1:0] ndiv_for(input logic [1:0] sel);
        logic [NDIV_W-1:0] r;
        unique case (sel)
            FSEL_FULL: r = NDIV_FULL;
            FSEL_HALF: r = NDIV_HALF;
            FSEL_QRTR: r = NDIV_QRTR;
            default:   r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [1:0] code_for(input logic [NDIV_W-1:0] nd);
        logic [1:0] r;
        if (nd == NDIV_FULL)      r = FSEL_FULL;
        else if (nd == NDIV_HALF) r = FSEL_HALF;
        else if (nd == NDIV_QRTR) r = FSEL_QRTR;
        else                      r = 2'd0;
        return r;
    endfunction

    function automatic logic [GAIN_W-1:0] gain_word();
        logic [GAIN_W-1:0] w;
        w = '0;
        w[3:0]   = 4'd3;
        w[6:4]   = 3'd2;
        w[9:7]   = 3'd0;
        w[19:10] = 10'd50;
        return w;
    endfunction

endpackage

// File: rtl/pfs_poll_timer.sv
module pfs_poll_timer #(
    parameter int POLL_LIMIT = 1500,
    parameter int POLL_GAP   = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic lock,
    output logic seen,
    output logic expired
);
    localparam int GW = $clog2(POLL_GAP + 1);
    localparam int PW = $clog2(POLL_LIMIT + 1);

    logic [GW-1:0] gap_q;
    logic [PW-1:0] poll_q;
    logic          sample;

    assign sample  = run && (gap_q == GW'(POLL_GAP - 1));
    assign seen    = sample && lock;
    assign expired = sample && !lock && (poll_q == PW'(POLL_LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            poll_q <= '0;
        end else if (!run) begin
            gap_q  <= '0;
            poll_q <= '0;
        end else if (sample) begin
            gap_q  <= '0;
            poll_q <= poll_q + 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end
endmodule

// File: rtl/pfs_cluster_bank.sv
module pfs_cluster_bank
    import pfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  pfs_act_t          act,
    input  logic [NDIV_W-1:0] ndiv_i,
    output logic              core_rst_n,
    output logic              post_rst_n,
    output logic              bypass,
    output logic [DIVW_W-1:0] div_word,
    output logic [FRAC_W-1:0] frac_word,
    output logic [GAIN_W-1:0] gain,
    output logic              vco_upd
);
    localparam int GAP_W = DIVW_W - PDIV_W - NDIV_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_rst_n <= 1'b1;
            post_rst_n <= 1'b1;
            bypass     <= 1'b0;
            div_word   <= '0;
            frac_word  <= '0;
            gain       <= '0;
            vco_upd    <= 1'b0;
        end else begin
            vco_upd <= 1'b0;
            if (sel) begin
                if (act.byp_on)  bypass <= 1'b1;
                if (act.byp_off) bypass <= 1'b0;
                if (act.rst_all) begin
                    core_rst_n <= 1'b0;
                    post_rst_n <= 1'b0;
                end
                if (act.prog) begin
                    div_word  <= {PDIV_VAL, {GAP_W{1'b0}}, ndiv_i};
                    frac_word <= '0;
                    gain      <= gain_word();
                end
                if (act.core_rel)  core_rst_n <= 1'b1;
                if (act.post_rel)  post_rst_n <= 1'b1;
                if (act.vco_pulse) vco_upd    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pll_freq_seq.sv
module pll_freq_seq
    import pfs_pkg::*;
#(
    parameter int N_CLUSTERS = 4,
    parameter int IDX_W      = 3,
    parameter int POLL_LIMIT = 1500,
    parameter int POLL_GAP   = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [IDX_W-1:0]             cluster_i,
    input  logic [1:0]                   freq_sel_i,
    input  logic [N_CLUSTERS-1:0]        lock_i,
    input  logic [IDX_W-1:0]             rb_cluster_i,
    output logic [N_CLUSTERS-1:0]        core_rst_n_o,
    output logic [N_CLUSTERS-1:0]        post_rst_n_o,
    output logic [N_CLUSTERS-1:0]        bypass_o,
    output logic [DIVW_W*N_CLUSTERS-1:0] div_word_o,
    output logic [FRAC_W*N_CLUSTERS-1:0] frac_word_o,
    output logic [GAIN_W*N_CLUSTERS-1:0] gain_word_o,
    output logic [N_CLUSTERS-1:0]        vco_upd_o,
    output logic                         busy_o,
    output logic                         done_o,
    output logic                         ok_o,
    output logic                         timeout_o,
    output logic                         bad_sel_o,
    output logic [1:0]                   rb_code_o
);
    localparam int CL_W = (N_CLUSTERS > 1) ? $clog2(N_CLUSTERS) : 1;

    pfs_state_t        state_q, state_d;
    pfs_act_t          act;
    logic [CL_W-1:0]   clus_q, clus_in, rb_idx;
    logic [NDIV_W-1:0] ndiv_q;
    logic              to_q;
    logic              accept, reject;
    logic              lock_sel, poll_seen, poll_expired;
    logic [DIVW_W-1:0] div_arr [N_CLUSTERS];

    assign clus_in = (cluster_i < IDX_W'(N_CLUSTERS)) ? CL_W'(cluster_i) : '0;
    assign rb_idx  = (rb_cluster_i < IDX_W'(N_CLUSTERS)) ? CL_W'(rb_cluster_i) : '0;
    assign accept  = (state_q == ST_IDLE) && start_i && sel_valid(freq_sel_i);
    assign reject  = (state_q == ST_IDLE) && start_i && !sel_valid(freq_sel_i);
    assign lock_sel = lock_i[clus_q];

    pfs_poll_timer #(
        .POLL_LIMIT(POLL_LIMIT),
        .POLL_GAP  (POLL_GAP)
    ) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_LOCKWAIT),
        .lock   (lock_sel),
        .seen   (poll_seen),
        .expired(poll_expired)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept) state_d = ST_BYPASS;
            ST_BYPASS:   state_d = ST_RESET;
            ST_RESET:    state_d = ST_PROGRAM;
            ST_PROGRAM:  state_d = ST_RELEASE;
            ST_RELEASE:  state_d = ST_UPDATE;
            ST_UPDATE:   state_d = ST_LOCKWAIT;
            ST_LOCKWAIT: if (poll_seen || poll_expired) state_d = ST_POSTREL;
            ST_POSTREL:  state_d = ST_UNBYPASS;
            ST_UNBYPASS: state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        act = '0;
        unique case (state_q)
            ST_BYPASS:   act.byp_on    = 1'b1;
            ST_RESET:    act.rst_all   = 1'b1;
            ST_PROGRAM:  act.prog      = 1'b1;
            ST_RELEASE:  act.core_rel  = 1'b1;
            ST_UPDATE:   act.vco_pulse = 1'b1;
            ST_POSTREL:  act.post_rel  = 1'b1;
            ST_UNBYPASS: act.byp_off   = 1'b1;
            default:     act = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_o    <= 1'b0;
            done_o    <= 1'b0;
            ok_o      <= 1'b0;
            timeout_o <= 1'b0;
            bad_sel_o <= 1'b0;
            to_q      <= 1'b0;
            clus_q    <= '0;
            ndiv_q    <= '0;
        end else begin
            done_o <= 1'b0;
            if (accept) begin
                busy_o    <= 1'b1;
                ok_o      <= 1'b0;
                timeout_o <= 1'b0;
                bad_sel_o <= 1'b0;
                to_q      <= 1'b0;
                clus_q    <= clus_in;
                ndiv_q    <= ndiv_for(freq_sel_i);
            end
            if (reject) begin
                done_o    <= 1'b1;
                ok_o      <= 1'b0;
                timeout_o <= 1'b0;
                bad_sel_o <= 1'b1;
            end
            if (poll_expired) to_q <= 1'b1;
            if (state_q == ST_FINISH) begin
                busy_o    <= 1'b0;
                done_o    <= 1'b1;
                ok_o      <= !to_q;
                timeout_o <= to_q;
            end
        end
    end

    for (genvar g = 0; g < N_CLUSTERS; g++) begin : g_bank
        pfs_cluster_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (clus_q == CL_W'(g)),
            .act       (act),
            .ndiv_i    (ndiv_q),
            .core_rst_n(core_rst_n_o[g]),
            .post_rst_n(post_rst_n_o[g]),
            .bypass    (bypass_o[g]),
            .div_word  (div_word_o[g*DIVW_W +: DIVW_W]),
            .frac_word (frac_word_o[g*FRAC_W +: FRAC_W]),
            .gain      (gain_word_o[g*GAIN_W +: GAIN_W]),
            .vco_upd   (vco_upd_o[g])
        );
        assign div_arr[g] = div_word_o[g*DIVW_W +: DIVW_W];
    end

    assign rb_code_o = code_for(div_arr[rb_idx][NDIV_W-1:0]);

endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
    parameter int N_CLUSTERS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  busy_o,
    input logic                  done_o,
    input logic                  ok_o,
    input logic                  timeout_o,
    input logic [N_CLUSTERS-1:0] core_rst_n_o,
    input logic [N_CLUSTERS-1:0] post_rst_n_o,
    input logic [N_CLUSTERS-1:0] bypass_o,
    input logic [N_CLUSTERS-1:0] vco_upd_o
);
    assert_vco_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|vco_upd_o) |=> !(|vco_upd_o));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_one_cluster_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vco_upd_o) && $onehot0(bypass_o));

    assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(ok_o && timeout_o));

    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    for (genvar g = 0; g < N_CLUSTERS; g++) begin : g_chk
        assert_post_after_core_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !core_rst_n_o[g] |-> !post_rst_n_o[g]);

        assert_vco_in_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
            vco_upd_o[g] |-> (bypass_o[g] && core_rst_n_o[g] && !post_rst_n_o[g]));

        assert_unbypass_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(bypass_o[g]) |-> post_rst_n_o[g]);
    end
endmodule

bind pll_freq_seq pfs_checker #(.N_CLUSTERS(N_CLUSTERS)) u_pfs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .ok_o        (ok_o),
    .timeout_o   (timeout_o),
    .core_rst_n_o(core_rst_n_o),
    .post_rst_n_o(post_rst_n_o),
    .bypass_o    (bypass_o),
    .vco_upd_o   (vco_upd_o)
);

// File: tb/test_pll_freq_seq.sv
`timescale 1ns/1ps
module test_pll_freq_seq;
    localparam int N     = 4;
    localparam int IW    = 3;
    localparam int LIMIT = 6;
    localparam int GAP   = 4;
    localparam logic [19:0] GAIN_EXP = 20'hC823;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [IW-1:0] cluster_i = '0;
    logic [1:0]    freq_sel_i = '0;
    logic [N-1:0]  lock_i;
    logic [IW-1:0] rb_cluster_i = '0;
    logic [N-1:0]  core_rst_n_o, post_rst_n_o, bypass_o, vco_upd_o;
    logic [16*N-1:0] div_word_o;
    logic [20*N-1:0] frac_word_o, gain_word_o;
    logic busy_o, done_o, ok_o, timeout_o, bad_sel_o;
    logic [1:0] rb_code_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    int lock_dly [N];
    logic [15:0] exp_div [N];

    always #2.5 clk = ~clk;

    pll_freq_seq #(.N_CLUSTERS(N), .IDX_W(IW), .POLL_LIMIT(LIMIT), .POLL_GAP(GAP)) i_pll_freq_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cluster_i(cluster_i),
        .freq_sel_i(freq_sel_i), .lock_i(lock_i), .rb_cluster_i(rb_cluster_i),
        .core_rst_n_o(core_rst_n_o), .post_rst_n_o(post_rst_n_o), .bypass_o(bypass_o),
        .div_word_o(div_word_o), .frac_word_o(frac_word_o), .gain_word_o(gain_word_o),
        .vco_upd_o(vco_upd_o), .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o),
        .timeout_o(timeout_o), .bad_sel_o(bad_sel_o), .rb_code_o(rb_code_o)
    );

    // PLL lock model: lock rises lock_dly cycles after the VCO update pulse
    for (genvar c = 0; c < N; c++) begin : g_lk
        int cnt;
        logic lk;
        always @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt <= 0; lk <= 1'b0;
            end else if (!core_rst_n_o[c]) begin
                cnt <= 0; lk <= 1'b0;
            end else if (vco_upd_o[c]) begin
                cnt <= 1;
            end else if (cnt != 0) begin
                if (cnt >= lock_dly[c]) lk <= 1'b1;
                else cnt <= cnt + 1;
            end
        end
        assign lock_i[c] = lk;
    end

    typedef struct packed {
        logic [2:0] idx;
        logic [1:0] sel;
        logic [7:0] dly;
        logic [9:0] ndiv;
        logic [1:0] code;
        logic [1:0] cl;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'd0, 2'd1, 8'd2,  10'h078, 2'd1, 2'd0},
        '{3'd1, 2'd2, 8'd5,  10'h03C, 2'd2, 2'd1},
        '{3'd2, 2'd3, 8'd1,  10'h01E, 2'd3, 2'd2},
        '{3'd3, 2'd1, 8'd10, 10'h078, 2'd1, 2'd3},
        '{3'd5, 2'd2, 8'd3,  10'h03C, 2'd2, 2'd0},
        '{3'd1, 2'd3, 8'd40, 10'h01E, 2'd3, 2'd1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all_words(input string req);
        for (int c = 0; c < N; c++)
            chk(req, 32'(div_word_o[c*16 +: 16]), 32'(exp_div[c]));
    endtask

    task automatic run_seq(input logic [2:0] idx, input logic [1:0] sel, input int dly,
                           input int cl, input logic [9:0] nd, input logic [1:0] code,
                           input bit poke);
        int n, j, exp_n;
        bit exp_to;
        lock_dly[cl] = dly;
        j = (2 + dly + GAP - 1) / GAP;
        if (j < 1) j = 1;
        if (j > LIMIT) begin exp_to = 1; exp_n = 8 + GAP * LIMIT; end
        else begin exp_to = 0; exp_n = 8 + GAP * j; end
        @(negedge clk);
        cluster_i = idx; freq_sel_i = sel; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        chk("R2 busy after start", 32'(busy_o), 32'd1);
        n = 0;
        while (!done_o && n < 2000) begin
            @(posedge clk); n++; #1;
            if (n == 1) chk("R2 step1 bypass", {bypass_o[cl], core_rst_n_o[cl], post_rst_n_o[cl]}, 3'b111);
            if (n == 2) chk("R2 step2 resets", {bypass_o[cl], core_rst_n_o[cl], post_rst_n_o[cl]}, 3'b100);
            if (n == 3) begin
                chk("R3 divider word", 32'(div_word_o[cl*16 +: 16]), {16'd0, 4'h1, 2'b00, nd});
                chk("R3 frac word", 32'(frac_word_o[cl*20 +: 20]), 32'd0);
                chk("R4 gain word", 32'(gain_word_o[cl*20 +: 20]), 32'(GAIN_EXP));
                if (poke) begin cluster_i = 3'd3; freq_sel_i = 2'd2; start_i = 1'b1; end
            end
            if (n == 4) begin
                start_i = 1'b0;
                chk("R2 step4 core released", {core_rst_n_o[cl], post_rst_n_o[cl]}, 2'b10);
            end
            if (n == 5) chk("R2 step5 vco pulse", 32'(vco_upd_o[cl]), 32'd1);
            if (n == 6) chk("R10 vco pulse width", 32'(vco_upd_o), 32'd0);
        end
        exp_div[cl] = {4'h1, 2'b00, nd};
        chk(exp_to ? "R7 cycles to done" : "R6 cycles to done", n, exp_n);
        chk("R7 ok/timeout flags", {ok_o, timeout_o, bad_sel_o, busy_o}, {~exp_to, exp_to, 2'b00});
        chk("R7 final reset/bypass", {core_rst_n_o[cl], post_rst_n_o[cl], bypass_o}, {2'b11, 4'b0000});
        check_all_words("R8 per-cluster words");
        rb_cluster_i = 3'(cl); #1;
        chk("R9 readback", 32'(rb_code_o), 32'(code));
        @(posedge clk); #1;
        chk("R10 done width", 32'(done_o), 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < N; c++) begin lock_dly[c] = 1; exp_div[c] = '0; end
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 resets", {core_rst_n_o, post_rst_n_o}, 8'hFF);
        chk("R1 bypass/vco", {bypass_o, vco_upd_o}, 8'h00);
        chk("R1 flags", {busy_o, done_o, ok_o, timeout_o, bad_sel_o}, 5'b0);
        chk("R1 words", 32'(|{div_word_o, frac_word_o, gain_word_o}), 32'd0);
        chk("R1 readback", 32'(rb_code_o), 32'd0);
        rst_n = 1'b1;
        @(posedge clk);

        for (int v = 0; v < 6; v++)
            run_seq(VECS[v].idx, VECS[v].sel, int'(VECS[v].dly), int'(VECS[v].cl),
                    VECS[v].ndiv, VECS[v].code, 1'b0);

        // R9 readback with out-of-range index goes to cluster 0 (holds 0x3C)
        rb_cluster_i = 3'd6; #1;
        chk("R9 readback fallback", 32'(rb_code_o), 32'd2);

        // R5 unsupported code 0
        @(negedge clk);
        cluster_i = 3'd2; freq_sel_i = 2'd0; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        chk("R5 reject flags", {done_o, bad_sel_o, busy_o, ok_o}, 4'b1100);
        chk("R5 no bypass", 32'(bypass_o), 32'd0);
        check_all_words("R5 words untouched");
        repeat (3) @(posedge clk); #1;
        chk("R5 stays idle", {busy_o, done_o, bypass_o}, 6'b0);

        // R11 start while busy is ignored
        run_seq(3'd2, 2'd1, 2, 2, 10'h078, 2'd1, 1'b1);
        begin
            int extra;
            extra = 0;
            repeat (40) begin
                @(posedge clk); #1;
                if (busy_o || done_o) extra++;
            end
            chk("R11 no second run", extra, 0);
        end
        check_all_words("R11 cluster 3 untouched");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule